// File: doc/BRIEF.md
# Shortest-Path Deflection Switching Element

This element sits in one row of a shuffle-exchange fabric of N = 2^n lines, where every stage is followed by a perfect shuffle. Each cycle it takes up to two cell headers, each a valid flag and an n-bit destination outlet. It places each header on one of four outlets. Two are local outlets that exit to the output queues of lines {row,0} and {row,1}. The other two are interstage outlets that feed the next stage.

The element works out each cell's output distance from the destination alone. The distance is the number of further stages the cell must cross before it reaches the row that owns its destination. When both cells want the same outlet, the cell nearer its destination keeps the outlet and the other is deflected onto an interstage link. A ties-breaking pseudo-random bit decides between equally distant cells, and also picks the link for a cell that loses a local outlet. Every result is registered, and each outlet reports the destination and the distance so that later stages or a monitor can follow the route.

Top module: `defl_se`

## Requirements
- R1: While rst_n is low, all four outlet valid bits are 0.
- R2: An outlet is valid exactly one clock edge after the input cycle that produced it. The number of valid outlets equals the number of valid inputs in the previous cycle.
- R3: With the element's row address r (n-1 bits), a cell's distance is the smallest k in 0..n-1 such that r[n-2-k:0] equals dst[n-1:k+1]. An empty comparison always matches, so k = n-1 is the largest value.
- R4: A cell at distance 0 requests local outlet dst[0]. Port index 0 is local outlet 0 and port index 1 is local outlet 1. A valid local outlet therefore always carries distance 0 and destination {r, port}.
- R5: A cell at distance k > 0 requests interstage outlet dst[k]. Port index 2 is interstage outlet 0 and port index 3 is interstage outlet 1.
- R6: Two valid cells that request different outlets each get the outlet they requested.
- R7: When both cells request the same outlet and their distances differ, the smaller distance wins that outlet. A loser of an interstage contention takes the other interstage outlet.
- R8: When both cells request the same outlet at equal distance, the winner is chosen by bit 0 of a 16-bit LFSR that advances every cycle, so over repeated ties each input wins at least once.
- R9: The loser of a local-outlet contention goes to interstage outlet 0 or 1, chosen by LFSR bit 1, so both links are used over repeated ties.
- R10: An invalid input never contends and never produces an outlet.
- R11: Each outlet carries its cell's destination unchanged and the distance that was computed at this element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_vld | input | 1 | Header on inlet 0 is valid |
| a_dst | input | NB | Destination outlet of inlet 0 cell |
| b_vld | input | 1 | Header on inlet 1 is valid |
| b_dst | input | NB | Destination outlet of inlet 1 cell |
| o_vld | output | 4 | Valid per outlet (0,1 local; 2,3 interstage) |
| o_dst | output | 4*NB | Destination per outlet, outlet p at [p*NB +: NB] |
| o_dist | output | 4*DW | Distance per outlet, outlet p at [p*DW +: DW] |

## Verification
Several properties are checked on every cycle. The count of valid outlets must match the count of valid inputs in the previous cycle. A valid local outlet must hold a distance-0 cell addressed to that outlet's line. When both interstage outlets carry cells at differing nonzero distances, the nearer cell must sit on the outlet it requested. Only the bench scenarios can show the rest: the exact distance and outlet for every destination, priority by distance, and that ties and local-loser deflections fall both ways over many repetitions.

// File: rtl/defl_se.sv
module defl_se #(
  parameter int NB = 4,
  parameter int ROW = 5,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int DW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_vld,
  input  logic [NB-1:0]   a_dst,
  input  logic            b_vld,
  input  logic [NB-1:0]   b_dst,
  output logic [3:0]      o_vld,
  output logic [4*NB-1:0] o_dst,
  output logic [4*DW-1:0] o_dist
);
  localparam logic [NB-1:0] RWIDE = NB'(ROW) & {1'b0, {(NB-1){1'b1}}};

  function automatic logic [DW-1:0] dist_of(input logic [NB-1:0] dst);
    logic [DW-1:0] d;
    logic [NB-1:0] mask;
    d = DW'(NB - 1);
    for (int k = NB - 1; k >= 0; k--) begin
      mask = {NB{1'b1}} << (k + 1);
      if ((((RWIDE << (k + 1)) ^ dst) & mask) == '0) d = DW'(k);
    end
    return d;
  endfunction

  function automatic logic [1:0] req_of(input logic [NB-1:0] dst, input logic [DW-1:0] d);
    return (d == '0) ? {1'b0, dst[0]} : {1'b1, dst[d]};
  endfunction

  logic [15:0]   lfsr;
  logic [DW-1:0] da, db;
  logic [1:0]    ra, rb, pa, pb;
  logic          clash, a_wins;

  assign da     = dist_of(a_dst);
  assign db     = dist_of(b_dst);
  assign ra     = req_of(a_dst, da);
  assign rb     = req_of(b_dst, db);
  assign clash  = a_vld && b_vld && (ra == rb);
  assign a_wins = (da < db) || ((da == db) && !lfsr[0]);

  always_comb begin
    logic [1:0] lose;
    lose = ra[1] ? {1'b1, ~ra[0]} : {1'b1, lfsr[1]};
    pa = ra;
    pb = rb;
    if (clash) begin
      pa = a_wins ? ra : lose;
      pb = a_wins ? lose : rb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {lfsr[14:0], 1'b0} ^ (lfsr[15] ? 16'h002D : 16'h0000);
  end

  logic [3:0]      n_vld;
  logic [4*NB-1:0] n_dst;
  logic [4*DW-1:0] n_dist;

  always_comb begin
    n_vld  = '0;
    n_dst  = '0;
    n_dist = '0;
    for (int p = 0; p < 4; p++) begin
      if (a_vld && pa == 2'(p)) begin
        n_vld[p]            = 1'b1;
        n_dst[p*NB +: NB]   = a_dst;
        n_dist[p*DW +: DW]  = da;
      end else if (b_vld && pb == 2'(p)) begin
        n_vld[p]            = 1'b1;
        n_dst[p*NB +: NB]   = b_dst;
        n_dist[p*DW +: DW]  = db;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld  <= '0;
      o_dst  <= '0;
      o_dist <= '0;
    end else begin
      o_vld  <= n_vld;
      o_dst  <= n_dst;
      o_dist <= n_dist;
    end
  end
endmodule

// File: rtl/defl_se_chk.sv
module defl_se_chk #(
  parameter int NB = 4,
  parameter int ROW = 5,
  localparam int DW = (NB > 1) ? $clog2(NB) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            a_vld,
  input logic [NB-1:0]   a_dst,
  input logic            b_vld,
  input logic [NB-1:0]   b_dst,
  input logic [3:0]      o_vld,
  input logic [4*NB-1:0] o_dst,
  input logic [4*DW-1:0] o_dist
);
  localparam logic [NB-2:0] RADR = ROW[NB-2:0];

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic [NB-1:0] d2, d3;
  logic [DW-1:0] k2, k3;
  assign d2 = o_dst[2*NB +: NB];
  assign d3 = o_dst[3*NB +: NB];
  assign k2 = o_dist[2*DW +: DW];
  assign k3 = o_dist[3*DW +: DW];

  a_r2_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> $countones(o_vld) == int'($past(a_vld)) + int'($past(b_vld)));

  a_r10_single_input: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(a_vld) && !$past(b_vld) |-> $countones(o_vld) == 1);

  a_r4_local0_home: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld[0] |-> (o_dist[0 +: DW] == '0) && (o_dst[0 +: NB] == {RADR, 1'b0}));

  a_r4_local1_home: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld[1] |-> (o_dist[DW +: DW] == '0) && (o_dst[NB +: NB] == {RADR, 1'b1}));

  a_r7_nearer_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    o_vld[2] && o_vld[3] && k2 != '0 && k3 != '0 && k2 != k3 |->
      ((k2 < k3) ? (d2[k2] == 1'b0) : (d3[k3] == 1'b1)));
endmodule

bind defl_se defl_se_chk #(.NB(NB), .ROW(ROW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .a_dst(a_dst), .b_vld(b_vld),
  .b_dst(b_dst), .o_vld(o_vld), .o_dst(o_dst), .o_dist(o_dist));

// File: tb/sim_defl_se.sv
module sim_defl_se;
  localparam int NB = 4;
  localparam int ROW = 5;
  localparam int DW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_vld = 1'b0, b_vld = 1'b0;
  logic [NB-1:0] a_dst = '0, b_dst = '0;
  logic [3:0] o_vld;
  logic [4*NB-1:0] o_dst;
  logic [4*DW-1:0] o_dist;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  defl_se #(.NB(NB), .ROW(ROW)) u0 (.clk(clk), .rst_n(rst_n), .a_vld(a_vld), .a_dst(a_dst),
    .b_vld(b_vld), .b_dst(b_dst), .o_vld(o_vld), .o_dst(o_dst), .o_dist(o_dist));

  // {av, ad, bv, bd, port_a, dist_a, port_b, dist_b}
  localparam logic [17:0] VEC [12] = '{
    {1'b1,4'd10,1'b0,4'd0, 2'd0,2'd0,2'd0,2'd0},
    {1'b0,4'd0, 1'b1,4'd11,2'd0,2'd0,2'd1,2'd0},
    {1'b1,4'd10,1'b1,4'd11,2'd0,2'd0,2'd1,2'd0},
    {1'b1,4'd4, 1'b1,4'd12,2'd2,2'd1,2'd3,2'd2},
    {1'b1,4'd4, 1'b1,4'd8, 2'd2,2'd1,2'd3,2'd2},
    {1'b1,4'd0, 1'b1,4'd5, 2'd3,2'd3,2'd2,2'd1},
    {1'b1,4'd14,1'b1,4'd7, 2'd2,2'd2,2'd3,2'd1},
    {1'b1,4'd10,1'b1,4'd4, 2'd0,2'd0,2'd2,2'd1},
    {1'b0,4'd3, 1'b0,4'd9, 2'd0,2'd0,2'd0,2'd0},
    {1'b0,4'd4, 1'b1,4'd4, 2'd0,2'd0,2'd2,2'd1},
    {1'b1,4'd6, 1'b1,4'd0, 2'd3,2'd1,2'd2,2'd3},
    {1'b1,4'd11,1'b1,4'd9, 2'd1,2'd0,2'd2,2'd2}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic av, input logic [NB-1:0] ad, input logic bv, input logic [NB-1:0] bd);
    @(negedge clk);
    a_vld = av; a_dst = ad; b_vld = bv; b_dst = bd;
    @(negedge clk);
    a_vld = 1'b0; b_vld = 1'b0;
  endtask

  function automatic int mdist(input logic [NB-1:0] dst);
    logic [NB-2:0] r;
    r = ROW[NB-2:0];
    for (int k = 0; k < NB; k++) begin
      bit ok;
      ok = 1;
      for (int j = k + 1; j < NB; j++) if (dst[j] != r[j-k-1]) ok = 0;
      if (ok) return k;
    end
    return NB - 1;
  endfunction

  initial begin
    #4000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int wa, loc2, loc3;
    repeat (3) @(negedge clk);
    chk(o_vld == 4'b0000, "R1 reset valid", o_vld, 0);
    rst_n = 1'b1;

    // table walk: R4 R5 R6 R7 R10 R11
    foreach (VEC[i]) begin
      logic [17:0] v;
      logic [3:0] ev;
      v = VEC[i];
      ev = '0;
      if (v[17]) ev[v[7:6]] = 1'b1;
      if (v[12]) ev[v[3:2]] = 1'b1;
      apply(v[17], v[16:13], v[12], v[11:8]);
      chk(o_vld == ev, $sformatf("R6/R7/R10 vector %0d valid", i), o_vld, ev);
      if (v[17]) begin
        chk(o_dst[v[7:6]*NB +: NB] == v[16:13], $sformatf("R11 vector %0d a dst", i), o_dst[v[7:6]*NB +: NB], v[16:13]);
        chk(o_dist[v[7:6]*DW +: DW] == v[5:4], $sformatf("R3 vector %0d a dist", i), o_dist[v[7:6]*DW +: DW], v[5:4]);
      end
      if (v[12]) begin
        chk(o_dst[v[3:2]*NB +: NB] == v[11:8], $sformatf("R11 vector %0d b dst", i), o_dst[v[3:2]*NB +: NB], v[11:8]);
        chk(o_dist[v[3:2]*DW +: DW] == v[1:0], $sformatf("R3 vector %0d b dist", i), o_dist[v[3:2]*DW +: DW], v[1:0]);
      end
    end

    // sweep of every destination: R3 R4 R5
    for (int d = 0; d < 16; d++) begin
      int k, p;
      k = mdist(4'(d));
      p = (k == 0) ? (d & 1) : 2 + ((d >> k) & 1);
      apply(1'b1, 4'(d), 1'b0, '0);
      chk(o_vld == 4'(1 << p), $sformatf("R4/R5 dst %0d port", d), o_vld, 1 << p);
      chk(o_dist[p*DW +: DW] == 2'(k), $sformatf("R3 dst %0d dist", d), o_dist[p*DW +: DW], k);
    end

    // latency: R2
    @(negedge clk);
    a_vld = 1'b1; a_dst = 4'd12;
    @(posedge clk); #1;
    chk(o_vld == 4'b1000, "R2 output one edge later", o_vld, 8);
    a_vld = 1'b0;
    @(posedge clk); #1;
    chk(o_vld == 4'b0000, "R2 drops after input leaves", o_vld, 0);

    // ties: R8 interstage, R9 local
    wa = 0; loc2 = 0; loc3 = 0;
    for (int t = 0; t < 40; t++) begin
      apply(1'b1, 4'd4, 1'b1, 4'd5);
      chk(o_vld == 4'b1100, "R8 tie both interstage", o_vld, 12);
      chk((o_dst[2*NB +: NB] ^ o_dst[3*NB +: NB]) == 4'd1, "R8 tie cells distinct", o_dst[3*NB +: NB], 0);
      if (o_dst[2*NB +: NB] == 4'd4) wa++;
      apply(1'b1, 4'd10, 1'b1, 4'd10);
      chk(o_vld == 4'b0101 || o_vld == 4'b1001, "R9 local loser on interstage", o_vld, 5);
      if (o_vld[2]) loc2++;
      if (o_vld[3]) loc3++;
    end
    chk(wa > 0 && wa < 40, "R8 each input wins some ties", wa, 20);
    chk(loc2 > 0 && loc3 > 0, "R9 both deflection links used", loc2, 20);

    // reset while active: R1
    @(negedge clk);
    a_vld = 1'b1; a_dst = 4'd10; b_vld = 1'b1; b_dst = 4'd4;
    rst_n = 1'b0;
    @(negedge clk);
    chk(o_vld == 4'b0000, "R1 reset overrides inputs", o_vld, 0);
    a_vld = 1'b0; b_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule